// File: doc/BRIEF.md
# Macro Instruction Sequencer

This block runs short macro programs held in a local code memory. Each 32-bit word carries an operation, three register indices and a result mode. The sequencer keeps eight general registers, a program counter and the delayed-branch state. It fetches and decodes one word per cycle. Arithmetic, bitfield and host-read results come from an outside execution unit. The sequencer sends that unit the whole instruction word and both source operands, and it gets back a single combinational result.

A program is written through the code load port. Its input parameters go into a small queue through a push port. A start pulse clears the core and moves the first parameter into register 1, and execution then begins at address 0. Each instruction picks one of eight result modes. These decide whether the destination gets the execution result or the next parameter, whether a method-address update goes out, and what value is sent to the host engine. Branches test a register against zero and can carry a delay slot. An exit bit stops the program after one further instruction has run.

Top module: `macro_seq`

## Requirements
- R1: The instruction fields are: operation [2:0] (0 ALU, 1 add-immediate, 2–4 bitfield forms, 5 read, 6 invalid, 7 branch), result mode [6:4], exit [7], destination [10:8], source A [13:11] and source B [16:14]. xu_a and xu_b carry the source registers. Register 0 reads as zero, and writes to it are discarded.
- R2: A start pulse while halted or idle clears all registers and the PC, drops done and error, and then loads the first queued parameter into register 1 before the first instruction. A start pulse during execution is ignored.
- R3: Result modes 0, 3 and 5 write the fetched parameter into the destination. Modes 1, 2, 4, 6 and 7 write the execution result there.
- R4: Modes 2, 5, 6 and 7 pulse mth_set for one cycle with mth_addr equal to the execution result.
- R5: Modes 3, 4 and 7 pulse snd_vld with the execution result as data. Mode 6 sends the fetched parameter. When mth_set and snd_vld share a cycle, the host applies the address first.
- R6: A branch (operation 7) is taken when bit 4 is 0 and source A equals zero, or when bit 4 is 1 and source A is nonzero. Its target is the branch's own PC plus the sign-extended field [31:14]. A branch writes no register and sends nothing.
- R7: A taken branch with bit 5 clear first runs the next sequential instruction and then continues at the target. With bit 5 set it continues at the target directly. A branch that is not taken continues sequentially.
- R8: An instruction with bit 7 set is followed by exactly one more sequential instruction, after which done rises and no further output is issued.
- R9: An instruction that needs a parameter while the queue is empty stalls. The PC holds and nothing is written or sent until a parameter arrives.
- R10: Operation 6 sets error and done together and has no side effect.
- R11: The parameter queue holds PQ_DEPTH words in order. prm_full is high when it is full, and a push while it is full is dropped.
- R12: Inside a delay slot, a branch or exit bit carried by that instruction is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a program at address 0 |
| done | output | 1 | Execution has halted |
| error | output | 1 | Halted on an invalid operation |
| cl_we | input | 1 | Code memory write enable |
| cl_addr | input | CODE_AW | Code memory write address |
| cl_data | input | 32 | Code memory write data |
| prm_push | input | 1 | Push a parameter into the queue |
| prm_data | input | 32 | Parameter value |
| prm_full | output | 1 | Parameter queue full |
| xu_insn | output | 32 | Current instruction to the execution unit |
| xu_a | output | 32 | Source A register value |
| xu_b | output | 32 | Source B register value |
| xu_res | input | 32 | Execution unit result, combinational |
| mth_set | output | 1 | Method-address update strobe |
| mth_addr | output | 32 | New method address |
| snd_vld | output | 1 | Send strobe |
| snd_data | output | 32 | Value sent to the host engine |

## Verification
The assertions assume that xu_res settles within the same cycle as the instruction word and operands, and that start is only pulsed while the core is idle or halted, unless the aim is to test that it is ignored. The bench's execution-unit model is a pure function of xu_insn, xu_a and xu_b. It loads code only while the core is halted and pulses start once per program. It pushes exactly the number of parameters each program consumes, except in the stall and queue-full cases, which starve or overfill the queue on purpose.

// File: rtl/macro_seq.sv
`timescale 1ns/1ps
module macro_seq #(
  parameter int CODE_AW  = 6,
  parameter int PQ_DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic               done,
  output logic               error,
  input  logic               cl_we,
  input  logic [CODE_AW-1:0] cl_addr,
  input  logic [31:0]        cl_data,
  input  logic               prm_push,
  input  logic [31:0]        prm_data,
  output logic               prm_full,
  output logic [31:0]        xu_insn,
  output logic [31:0]        xu_a,
  output logic [31:0]        xu_b,
  input  logic [31:0]        xu_res,
  output logic               mth_set,
  output logic [31:0]        mth_addr,
  output logic               snd_vld,
  output logic [31:0]        snd_data
);
  localparam int CODE_N = 1 << CODE_AW;
  localparam int PQ_AW  = $clog2(PQ_DEPTH);
  localparam logic [CODE_AW-1:0] PC_ONE  = CODE_AW'(1);
  localparam logic [PQ_AW-1:0]   PQ_LAST = PQ_AW'(PQ_DEPTH - 1);
  localparam logic [PQ_AW-1:0]   PTR_ONE = PQ_AW'(1);
  localparam logic [PQ_AW:0]     CNT_ONE = (PQ_AW+1)'(1);
  localparam logic [PQ_AW:0]     CNT_MAX = (PQ_AW+1)'(PQ_DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_RUN, S_HALT} st_t;
  st_t st;

  logic [31:0] code_mem [CODE_N];
  always_ff @(posedge clk)
    if (cl_we) code_mem[cl_addr] <= cl_data;

  logic [31:0]      pq [PQ_DEPTH];
  logic [PQ_AW-1:0] wp, rp;
  logic [PQ_AW:0]   cnt;
  logic             pq_empty, push_ok, pop;
  logic [31:0]      head;

  assign pq_empty = (cnt == '0);
  assign prm_full = (cnt == CNT_MAX);
  assign push_ok  = prm_push && !prm_full;
  assign head     = pq[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) begin
        pq[wp] <= prm_data;
        wp     <= (wp == PQ_LAST) ? '0 : wp + PTR_ONE;
      end
      if (pop)
        rp <= (rp == PQ_LAST) ? '0 : rp + PTR_ONE;
      case ({push_ok, pop})
        2'b10:   cnt <= cnt + CNT_ONE;
        2'b01:   cnt <= cnt - CNT_ONE;
        default: ;
      endcase
    end
  end

  logic [CODE_AW-1:0] pc, ds_tgt, target;
  logic               ds, ds_jump, ds_exit, err;
  logic [31:0]        gpr [8];
  logic [31:0]        insn, reg_a, reg_b, wdata;
  logic [2:0]         op, mode, dst, sa, sb;
  logic               is_br, is_bad, is_exe, is_exit;
  logic               md_prm, md_mth, md_snd, want_prm;
  logic               run, stall, fire, br_take, wr_en;

  assign insn    = code_mem[pc];
  assign op      = insn[2:0];
  assign mode    = insn[6:4];
  assign is_exit = insn[7];
  assign dst     = insn[10:8];
  assign sa      = insn[13:11];
  assign sb      = insn[16:14];
  assign target  = pc + insn[14 +: CODE_AW];

  assign reg_a = (sa == 3'd0) ? '0 : gpr[sa];
  assign reg_b = (sb == 3'd0) ? '0 : gpr[sb];
  assign xu_insn = insn;
  assign xu_a    = reg_a;
  assign xu_b    = reg_b;

  assign is_br  = (op == 3'd7);
  assign is_bad = (op == 3'd6);
  assign is_exe = !is_br && !is_bad;

  assign md_prm   = (mode == 3'd0) || (mode == 3'd3) || (mode == 3'd5);
  assign md_mth   = (mode == 3'd2) || (mode == 3'd5) || (mode == 3'd6) || (mode == 3'd7);
  assign md_snd   = (mode == 3'd3) || (mode == 3'd4) || (mode == 3'd6) || (mode == 3'd7);
  assign want_prm = is_exe && (md_prm || mode == 3'd6);

  assign run   = (st == S_RUN);
  assign stall = run && want_prm && pq_empty;
  assign fire  = run && !stall;
  assign pop   = (fire && want_prm) || (st == S_LOAD && !pq_empty);

  assign br_take = is_br && ((reg_a == '0) ^ insn[4]);
  assign wdata   = md_prm ? head : xu_res;
  assign wr_en   = fire && is_exe && (dst != 3'd0);

  assign mth_set  = fire && is_exe && md_mth;
  assign mth_addr = xu_res;
  assign snd_vld  = fire && is_exe && md_snd;
  assign snd_data = (mode == 3'd6) ? head : xu_res;

  assign done  = (st == S_HALT);
  assign error = err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      pc      <= '0;
      ds      <= 1'b0;
      ds_jump <= 1'b0;
      ds_exit <= 1'b0;
      ds_tgt  <= '0;
      err     <= 1'b0;
      for (int i = 0; i < 8; i++) gpr[i] <= '0;
    end else begin
      case (st)
        S_IDLE, S_HALT: if (start) begin
          st      <= S_LOAD;
          pc      <= '0;
          ds      <= 1'b0;
          ds_jump <= 1'b0;
          ds_exit <= 1'b0;
          err     <= 1'b0;
          for (int i = 0; i < 8; i++) gpr[i] <= '0;
        end
        S_LOAD: if (!pq_empty) begin
          gpr[1] <= head;
          st     <= S_RUN;
        end
        default: if (fire) begin
          if (wr_en) gpr[dst] <= wdata;
          if (is_bad) begin
            err <= 1'b1;
            st  <= S_HALT;
          end else if (ds) begin
            ds <= 1'b0;
            if (ds_exit) st <= S_HALT;
            else         pc <= ds_jump ? ds_tgt : pc + PC_ONE;
          end else if (is_exit) begin
            ds      <= 1'b1;
            ds_exit <= 1'b1;
            ds_jump <= 1'b0;
            pc      <= pc + PC_ONE;
          end else if (br_take && insn[5]) begin
            pc <= target;
          end else if (br_take) begin
            ds      <= 1'b1;
            ds_jump <= 1'b1;
            ds_exit <= 1'b0;
            ds_tgt  <= target;
            pc      <= pc + PC_ONE;
          end else begin
            pc <= pc + PC_ONE;
          end
        end
      endcase
    end
  end
endmodule

module macro_seq_chk #(
  parameter int CODE_AW  = 6,
  parameter int PQ_DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       start,
  input logic                       done,
  input logic                       error,
  input logic                       snd_vld,
  input logic                       mth_set,
  input logic                       stall,
  input logic [CODE_AW-1:0]         pc,
  input logic [$clog2(PQ_DEPTH):0]  cnt
);
  assert_error_halts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> done);

  assert_quiet_when_halted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!snd_vld && !mth_set));

  assert_stall_holds_pc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(pc));

  assert_queue_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= ($clog2(PQ_DEPTH)+1)'(PQ_DEPTH));

  assert_start_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && done) |=> (!done && !error));
endmodule

bind macro_seq macro_seq_chk #(.CODE_AW(CODE_AW), .PQ_DEPTH(PQ_DEPTH)) chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .error(error),
  .snd_vld(snd_vld), .mth_set(mth_set), .stall(stall), .pc(pc), .cnt(cnt)
);

// File: tb/macro_seq_test.sv
`timescale 1ns/1ps
module macro_seq_test;
  localparam int AW = 6;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic cl_we = 1'b0, prm_push = 1'b0;
  logic [AW-1:0] cl_addr = '0;
  logic [31:0] cl_data = '0, prm_data = '0;
  logic done, error, prm_full, mth_set, snd_vld;
  logic [31:0] xu_insn, xu_a, xu_b, xu_res, mth_addr, snd_data;

  macro_seq #(.CODE_AW(AW), .PQ_DEPTH(8)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .error(error),
    .cl_we(cl_we), .cl_addr(cl_addr), .cl_data(cl_data),
    .prm_push(prm_push), .prm_data(prm_data), .prm_full(prm_full),
    .xu_insn(xu_insn), .xu_a(xu_a), .xu_b(xu_b), .xu_res(xu_res),
    .mth_set(mth_set), .mth_addr(mth_addr), .snd_vld(snd_vld), .snd_data(snd_data)
  );

  always #2.5 clk = ~clk;

  assign xu_res = (xu_insn[2:0] == 3'd1) ? xu_a + {{14{xu_insn[31]}}, xu_insn[31:14]}
                                         : xu_a + xu_b;

  int n_cmp = 0, n_bad = 0, ns = 0, nm = 0;
  logic [31:0] sends [16];
  logic [31:0] sets  [16];
  logic [31:0] prog  [8];
  logic [31:0] exp_s [8];

  always @(negedge clk) if (rst_n) begin
    if (mth_set && nm < 16) begin sets[nm] = mth_addr; nm++; end
    if (snd_vld && ns < 16) begin sends[ns] = snd_data; ns++; end
  end

  // {insn, nsend, send0, send1, nset, set0}
  localparam logic [131:0] VEC [9] = '{
    {32'h00004B00, 2'd1, 32'h77, 32'h00, 2'd0, 32'h00},
    {32'h00004B10, 2'd1, 32'h20, 32'h00, 2'd0, 32'h00},
    {32'h00004B20, 2'd1, 32'h20, 32'h00, 2'd1, 32'h20},
    {32'h00004B30, 2'd2, 32'h20, 32'h77, 2'd0, 32'h00},
    {32'h00004B40, 2'd2, 32'h20, 32'h20, 2'd0, 32'h00},
    {32'h00004B50, 2'd1, 32'h77, 32'h00, 2'd1, 32'h20},
    {32'h00004B60, 2'd2, 32'h77, 32'h20, 2'd1, 32'h20},
    {32'h00004B70, 2'd2, 32'h20, 32'h20, 2'd1, 32'h20},
    {32'h00004810, 2'd1, 32'h00, 32'h00, 2'd0, 32'h00}
  };

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic load(input int n);
    for (int i = 0; i < n; i++) begin
      tick; cl_we = 1'b1; cl_addr = AW'(i); cl_data = prog[i];
    end
    tick; cl_we = 1'b0;
  endtask

  task automatic push(input logic [31:0] v);
    tick; prm_push = 1'b1; prm_data = v;
    tick; prm_push = 1'b0;
  endtask

  task automatic go;
    ns = 0; nm = 0;
    tick; start = 1'b1;
    tick; start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (!done && t < 1000) begin tick; t++; end
    chk(done, req, {31'd0, done}, 32'd1);
  endtask

  task automatic check_sends(input string req, input int n);
    chk(ns == n, req, ns, n);
    for (int i = 0; i < n && i < ns; i++) chk(sends[i] == exp_s[i], req, sends[i], exp_s[i]);
  endtask

  task automatic branch_run(input string req, input int n);
    load(6); go; push(32'h5); wait_done(req); check_sends(req, n);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog: actual hung expected finished");
    summary;
    $finish;
  end

  initial begin
    repeat (3) tick;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !error, "R2 reset state", {30'd0, done, error}, 32'd0);
    chk(!snd_vld && !mth_set && !prm_full, "R11 reset outputs", {29'd0, snd_vld, mth_set, prm_full}, 32'd0);

    // R3 R4 R5 R1: result modes, one instruction each
    for (int i = 0; i < 9; i++) begin
      logic [131:0] v;
      logic [31:0] ins;
      v = VEC[i];
      ins = v[131:100];
      prog[0] = ins;
      prog[1] = 32'hC0 | ({29'd0, ins[10:8]} << 11);
      prog[2] = 32'h10;
      load(3); go;
      push(32'h10);
      if (ins[6:4] == 3'd0 || ins[6:4] == 3'd3 || ins[6:4] == 3'd5 || ins[6:4] == 3'd6)
        push(32'h77);
      wait_done("R3 mode run");
      chk(ns == int'(v[99:98]), "R5 send count", ns, {30'd0, v[99:98]});
      if (ns > 0) chk(sends[0] == v[97:66], "R3/R5 first send", sends[0], v[97:66]);
      if (v[99:98] == 2'd2 && ns > 1) chk(sends[1] == v[65:34], "R5 second send", sends[1], v[65:34]);
      chk(nm == int'(v[33:32]), "R4 method count", nm, {30'd0, v[33:32]});
      if (v[33:32] != 2'd0 && nm > 0) chk(sets[0] == v[31:0], "R4 method addr", sets[0], v[31:0]);
      chk(!error, "R1 no error", {31'd0, error}, 32'd0);
    end

    // R7: taken branch, delay slot runs
    prog = '{32'hC007, 32'h4041, 32'h8041, 32'hC0C1, 32'h10041, 32'h14041, 32'h0, 32'h0};
    exp_s = '{32'd1, 32'd3, 32'd4, 0, 0, 0, 0, 0};
    branch_run("R7 delay slot", 3);
    // R7: annulled
    prog[0] = 32'hC027;
    exp_s = '{32'd3, 32'd4, 0, 0, 0, 0, 0, 0};
    branch_run("R7 annul", 2);
    // R6: nonzero on r0 not taken
    prog[0] = 32'hC037;
    exp_s = '{32'd1, 32'd2, 32'd3, 32'd4, 0, 0, 0, 0};
    branch_run("R6 not taken", 4);
    // R6: nonzero on r1 taken
    prog[0] = 32'hC837;
    exp_s = '{32'd3, 32'd4, 0, 0, 0, 0, 0, 0};
    branch_run("R6 nonzero taken", 2);
    // R6: backward target, R8 exit with delay slot
    prog = '{32'hC027, 32'h4041, 32'h80C1, 32'hC041, 32'hFFFF8027, 32'h0, 32'h0, 32'h0};
    exp_s = '{32'd3, 32'd2, 32'd3, 0, 0, 0, 0, 0};
    branch_run("R6 R8 backward", 3);
    // R12: branch inside delay slot ignored
    prog = '{32'h10007, 32'h8027, 32'h8041, 32'hC041, 32'h100C1, 32'h14041, 32'h0, 32'h0};
    exp_s = '{32'd4, 32'd5, 0, 0, 0, 0, 0, 0};
    branch_run("R12 slot branch", 2);

    // R10: invalid operation
    prog[0] = 32'h4041; prog[1] = 32'h46; prog[2] = 32'h8041;
    load(3); go; push(32'h5); wait_done("R10 halt");
    chk(error, "R10 error flag", {31'd0, error}, 32'd1);
    exp_s[0] = 32'd1;
    check_sends("R10 no side effect", 1);

    // R9: stall on empty queue; R2 start ignored while running
    prog[0] = 32'h0200; prog[1] = 32'h10C0; prog[2] = 32'h10;
    load(3); go;
    chk(!error && !done, "R2 start clears", {30'd0, done, error}, 32'd0);
    push(32'h5);
    repeat (10) tick;
    chk(ns == 0 && !done, "R9 stalled", ns, 32'd0);
    tick; start = 1'b1; tick; start = 1'b0;
    repeat (3) tick;
    push(32'hABC);
    wait_done("R9 resume");
    exp_s[0] = 32'hABC;
    check_sends("R9 R2 stalled fetch", 1);

    // R2: registers cleared by start
    prog[0] = 32'h10C0; prog[1] = 32'h10;
    load(2); go; push(32'h1); wait_done("R2 clear");
    exp_s[0] = 32'h0;
    check_sends("R2 r2 cleared", 1);

    // R11: queue fill, full flag, dropped push
    for (int i = 0; i < 8; i++) push(32'h100 + i);
    @(negedge clk);
    chk(prm_full, "R11 full", {31'd0, prm_full}, 32'd1);
    push(32'hDEAD);
    prog = '{32'h60, 32'h60, 32'h60, 32'h60, 32'h60, 32'h60, 32'hE0, 32'h10};
    load(8); go; wait_done("R11 drain");
    for (int i = 0; i < 7; i++) exp_s[i] = 32'h101 + i;
    check_sends("R11 order", 7);
    chk(nm == 7, "R4 mode 6 sets", nm, 32'd7);
    @(negedge clk);
    chk(!prm_full, "R11 drained", {31'd0, prm_full}, 32'd0);

    summary;
    $finish;
  end
endmodule